// File: doc/BRIEF.md
# Instruction Fetch Translation Buffer

This block is a four-slot, fully associative buffer that translates instruction fetch addresses. Each lookup compares the fetch address against all four slots at once. A slot matches when it is valid and its virtual page equals the fetch page under the slot's own page size. Its address space tag must also equal the current one, unless the slot is marked shared or the caller asks for the tag to be skipped. A single match returns the physical address and the slot flags one cycle after the request. Several matches return a multi-match indication instead of an address.

When nothing matches, the block asks a second-level translation store for the page over a valid/ready request channel. It then waits for the response. A found entry is written into the slot picked by a six-bit pseudo-LRU state, and the translation is returned. A response that reports no entry ends the lookup as a miss. Software can read and write the tag and data arrays directly. A single flush input drops every slot in one cycle. Protection checking and exception handling are left to the consumer of the result.

Top module: `itlb_fetch_xlat`

## Requirements
- R1: A slot matches when its valid flag (flag bit 8) is set, its page number equals the fetch page number under its page mask, and its shared flag (flag bit 1) is set or its 8-bit tag equals `lk_asid`. A lookup with exactly one match ends one cycle after `lk_req`, with `lk_done` and `lk_hit` high, `lk_paddr` = (slot page & mask) | (fetch address & ~mask) over bits [28:0], and `lk_flags` = the slot flags.
- R2: With `lk_asid_skip` high, a slot matches on its valid flag and masked page number alone, and the tag and the shared flag are ignored.
- R3: The page size comes from flag bits {7,4}: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. The page size sets both the compare mask and the split between page bits and offset bits in `lk_paddr`. An address one byte past a slot's page does not match that slot.
- R4: The victim slot is 0 when (state & 0x38) == 0x38. Otherwise it is 1 when (state & 0x26) == 0x06. Otherwise it is 2 when (state & 0x15) == 0x01. In every other case it is 3.
- R5: The LRU state resets to 0. Using slot N, either by a hit or by a fill, sets the state to: for N=0, state & 0x07; for N=1, (state & 0x19) | 0x20; for N=2, (state & 0x3E) | 0x14; for N=3, state | 0x0B. The state changes at no other time.
- R6: A lookup with more than one match ends one cycle later with `lk_done` and `lk_multi` high and `lk_hit` low. It leaves the LRU state unchanged.
- R7: A lookup with no match raises `rf_req_valid` with `rf_req_vaddr` equal to the fetch address. Both hold until `rf_req_ready` is high. `lk_ready` stays low until the response arrives. A response with `rf_rsp_found` high writes the victim slot with the returned page, tag, physical page and flags & 0x1DA. The same response ends the lookup as a hit carrying that translation.
- R8: A response with `rf_rsp_found` low ends the lookup with `lk_miss` high. No slot changes and the LRU state stays the same.
- R9: Array reads select the slot with `mm_entry` (address bits [8:7] of the array access). A tag read (`mm_data_sel` low) returns {page[31:10], 0, valid, tag[7:0]}. A data read returns {3'b0, physical page[28:10], 0, flags[8:0]}.
- R10: A tag write sets the page from bits [31:10], the valid flag from bit 8 and the tag from bits [7:0], and ignores bit 9. A data write sets the physical page from bits [28:10] and the flags from bits [8:0] & 0x1DA. Bits [31:29] are ignored.
- R11: A cycle with `flush_all` high clears the valid flag of every slot, and the flush takes effect on the next clock edge.
- R12: After reset every array word reads as zero, the LRU state is 0, `lk_ready` is high, and `lk_done` and `rf_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Clear all valid flags |
| lk_req | input | 1 | Start a lookup (taken when `lk_ready`) |
| lk_ready | output | 1 | Block idle, lookup accepted |
| lk_vaddr | input | 32 | Fetch virtual address |
| lk_asid | input | 8 | Current address space tag |
| lk_asid_skip | input | 1 | Match without the tag check |
| lk_done | output | 1 | Lookup result valid for one cycle |
| lk_hit | output | 1 | Translation found |
| lk_multi | output | 1 | More than one slot matched |
| lk_miss | output | 1 | Second level had no entry |
| lk_paddr | output | 29 | Translated physical address |
| lk_flags | output | 9 | Flags of the translating entry |
| rf_req_valid | output | 1 | Refill request pending |
| rf_req_ready | input | 1 | Refill request accepted |
| rf_req_vaddr | output | 32 | Address to refill |
| rf_rsp_valid | input | 1 | Refill response strobe |
| rf_rsp_found | input | 1 | Response carries an entry |
| rf_rsp_vpn | input | 22 | Returned virtual page [31:10] |
| rf_rsp_asid | input | 8 | Returned tag |
| rf_rsp_ppn | input | 19 | Returned physical page [28:10] |
| rf_rsp_flags | input | 9 | Returned flags |
| mm_we | input | 1 | Array write strobe |
| mm_data_sel | input | 1 | 0 = tag array, 1 = data array |
| mm_entry | input | 2 | Slot index (access address bits [8:7]) |
| mm_wdata | input | 32 | Array write word |
| mm_rdata | output | 32 | Array read word (combinational) |
| lru_state | output | 6 | Current pseudo-LRU state |

## Verification
The widths of this block are fixed by its word formats, so the bench builds it with the package defaults: 22-bit pages, an 8-bit tag and four slots. With four slots, a short chain of fills walks the LRU state through every victim choice. The four slots also hold one entry of each page size at the same time. This lets a single table of lookups cover every mask width, a shared entry and the tag-skip mode. A deliberate tag clash creates a real multi-match.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VPN_W   = 22;
  localparam int PPN_W   = 19;
  localparam int ASID_W  = 8;
  localparam int FLAG_W  = 9;
  localparam int PA_W    = 29;
  localparam int NUM_ENT = 4;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int LRU_W   = 6;
  localparam int FL_VALID  = 8;
  localparam int FL_SHARED = 1;
  localparam int FL_SZ_HI  = 7;
  localparam int FL_SZ_LO  = 4;
  localparam logic [FLAG_W-1:0] KEEP_FLAGS = 9'h1DA;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } slot_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ASK, ST_WAIT} seq_t;

  function automatic logic [1:0] size_code(input logic [FLAG_W-1:0] f);
    return {f[FL_SZ_HI], f[FL_SZ_LO]};
  endfunction

  // page-number compare mask over address bits [31:10]
  function automatic logic [VPN_W-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return '1;
      2'b01:   return {{(VPN_W-2){1'b1}}, 2'b0};
      2'b10:   return {{(VPN_W-6){1'b1}}, 6'b0};
      default: return {{(VPN_W-10){1'b1}}, 10'b0};
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] lru_victim(input logic [LRU_W-1:0] s);
    if ((s & 6'h38) == 6'h38)      return 2'd0;
    else if ((s & 6'h26) == 6'h06) return 2'd1;
    else if ((s & 6'h15) == 6'h01) return 2'd2;
    else                           return 2'd3;
  endfunction

  function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] s,
                                                 input logic [IDX_W-1:0] i);
    case (i)
      2'd0:    return s & 6'h07;
      2'd1:    return (s & 6'h19) | 6'h20;
      2'd2:    return (s & 6'h3E) | 6'h14;
      default: return s | 6'h0B;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] form_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [PA_W-1:0] va,
                                                 input logic [VPN_W-1:0] m);
    logic [PPN_W-1:0] pm;
    pm = m[PPN_W-1:0];
    return {(ppn & pm) | (va[PA_W-1:10] & ~pm), va[9:0]};
  endfunction
endpackage

// File: rtl/itlb_match.sv
module itlb_match
  import itlb_pkg::*;
(
  input  slot_t [NUM_ENT-1:0] ent,
  input  logic [VPN_W-1:0]    vpn,
  input  logic [ASID_W-1:0]   asid,
  input  logic                asid_skip,
  output logic [NUM_ENT-1:0]  hit_vec
);
  logic unused_ent;
  assign unused_ent = ^ent;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic [VPN_W-1:0] m;
    logic             page_eq;
    logic             tag_ok;
    assign m       = page_mask(size_code(ent[g].flags));
    assign page_eq = ((ent[g].vpn ^ vpn) & m) == '0;
    assign tag_ok  = asid_skip || ent[g].flags[FL_SHARED] || (ent[g].asid == asid);
    assign hit_vec[g] = ent[g].flags[FL_VALID] && page_eq && tag_ok;
  end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [LRU_W-1:0] state,
  output logic [IDX_W-1:0] victim
);
  always_ff @(posedge clk) begin
    if (!rst_n)        state <= '0;
    else if (touch_en) state <= lru_touch(state, touch_idx);
  end

  assign victim = lru_victim(state);

  // R5: state moves only when a slot is used
  p_lru_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_en |=> $stable(state));
endmodule

// File: rtl/itlb_fetch_xlat.sv
module itlb_fetch_xlat
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              lk_req,
  output logic              lk_ready,
  input  logic [31:0]       lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_asid_skip,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [FLAG_W-1:0] lk_flags,
  output logic              rf_req_valid,
  input  logic              rf_req_ready,
  output logic [31:0]       rf_req_vaddr,
  input  logic              rf_rsp_valid,
  input  logic              rf_rsp_found,
  input  logic [VPN_W-1:0]  rf_rsp_vpn,
  input  logic [ASID_W-1:0] rf_rsp_asid,
  input  logic [PPN_W-1:0]  rf_rsp_ppn,
  input  logic [FLAG_W-1:0] rf_rsp_flags,
  input  logic              mm_we,
  input  logic              mm_data_sel,
  input  logic [IDX_W-1:0]  mm_entry,
  input  logic [31:0]       mm_wdata,
  output logic [31:0]       mm_rdata,
  output logic [LRU_W-1:0]  lru_state
);
  slot_t [NUM_ENT-1:0] slots;
  seq_t                seq;
  logic [31:0]         va_q;
  logic [NUM_ENT-1:0]  match_vec;
  logic [NUM_ENT-1:0]  valid_vec;
  logic [IDX_W-1:0]    hit_idx;
  logic [IDX_W-1:0]    victim;
  logic [2:0]          n_match;
  logic                look_fire, single_hit, multi_hit, fill_fire, fill_ok;
  logic                touch_en;
  logic [IDX_W-1:0]    touch_idx;
  logic                unused_bits;

  assign unused_bits = ^{mm_wdata[31:29], mm_wdata[9]};

  itlb_match u_match (
    .ent(slots), .vpn(lk_vaddr[31:10]), .asid(lk_asid),
    .asid_skip(lk_asid_skip), .hit_vec(match_vec)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      valid_vec[i] = slots[i].flags[FL_VALID];
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign n_match    = 3'($countones(match_vec));
  assign look_fire  = lk_req && (seq == ST_IDLE);
  assign single_hit = look_fire && (n_match == 3'd1);
  assign multi_hit  = look_fire && (n_match > 3'd1);
  assign fill_fire  = (seq == ST_WAIT) && rf_rsp_valid;
  assign fill_ok    = fill_fire && rf_rsp_found;
  assign touch_en   = single_hit || fill_ok;
  assign touch_idx  = (seq == ST_WAIT) ? victim : hit_idx;

  itlb_lru u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .state(lru_state), .victim(victim)
  );

  assign lk_ready     = (seq == ST_IDLE);
  assign rf_req_valid = (seq == ST_ASK);
  assign rf_req_vaddr = va_q;

  // lookup sequencer and result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= ST_IDLE; va_q <= '0;
      lk_done <= 1'b0; lk_hit <= 1'b0; lk_multi <= 1'b0; lk_miss <= 1'b0;
      lk_paddr <= '0; lk_flags <= '0;
    end else begin
      lk_done <= 1'b0; lk_hit <= 1'b0; lk_multi <= 1'b0; lk_miss <= 1'b0;
      case (seq)
        ST_IDLE: if (look_fire) begin
          va_q <= lk_vaddr;
          if (single_hit) begin
            lk_done  <= 1'b1; lk_hit <= 1'b1;
            lk_paddr <= form_paddr(slots[hit_idx].ppn, lk_vaddr[PA_W-1:0],
                                   page_mask(size_code(slots[hit_idx].flags)));
            lk_flags <= slots[hit_idx].flags;
          end else if (multi_hit) begin
            lk_done <= 1'b1; lk_multi <= 1'b1;
          end else begin
            seq <= ST_ASK;
          end
        end
        ST_ASK: if (rf_req_ready) seq <= ST_WAIT;
        ST_WAIT: if (rf_rsp_valid) begin
          seq     <= ST_IDLE;
          lk_done <= 1'b1;
          if (rf_rsp_found) begin
            lk_hit   <= 1'b1;
            lk_paddr <= form_paddr(rf_rsp_ppn, va_q[PA_W-1:0],
                                   page_mask(size_code(rf_rsp_flags)));
            lk_flags <= rf_rsp_flags & KEEP_FLAGS;
          end else begin
            lk_miss <= 1'b1;
          end
        end
        default: seq <= ST_IDLE;
      endcase
    end
  end

  // slot storage: flush, then fill, then array write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (flush_all) begin
          slots[i].flags[FL_VALID] <= 1'b0;
        end else if (fill_ok && victim == IDX_W'(i)) begin
          slots[i].vpn   <= rf_rsp_vpn;
          slots[i].asid  <= rf_rsp_asid;
          slots[i].ppn   <= rf_rsp_ppn;
          slots[i].flags <= rf_rsp_flags & KEEP_FLAGS;
        end else if (mm_we && mm_entry == IDX_W'(i)) begin
          if (mm_data_sel) begin
            slots[i].ppn   <= mm_wdata[28:10];
            slots[i].flags <= mm_wdata[FLAG_W-1:0] & KEEP_FLAGS;
          end else begin
            slots[i].vpn             <= mm_wdata[31:10];
            slots[i].asid            <= mm_wdata[ASID_W-1:0];
            slots[i].flags[FL_VALID] <= mm_wdata[8];
          end
        end
      end
    end
  end

  assign mm_rdata = mm_data_sel
    ? {3'b0, slots[mm_entry].ppn, 1'b0, slots[mm_entry].flags}
    : {slots[mm_entry].vpn, 1'b0, slots[mm_entry].flags[FL_VALID], slots[mm_entry].asid};

  // R1: a finished lookup reports exactly one outcome
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $countones({lk_hit, lk_multi, lk_miss}) == 1);
  // R6: several matches end as multi-match with the LRU untouched
  p_multi_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (look_fire && n_match > 3'd1) |=> (lk_done && lk_multi && !lk_hit));
  p_multi_lru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (look_fire && n_match > 3'd1) |=> $stable(lru_state));
  // R7: request and its address hold until accepted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && !rf_req_ready) |=> (rf_req_valid && $stable(rf_req_vaddr)));
  // R7: a found fill leaves the victim slot valid
  p_fill_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && !flush_all) |=> valid_vec[$past(victim)]);
  // R8: an empty response leaves the LRU untouched
  p_empty_lru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !rf_rsp_found) |=> $stable(lru_state));
  // R11: flush drops every slot
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
endmodule

// File: tb/itlb_fetch_xlat_tb.sv
`timescale 1ns/1ps
module itlb_fetch_xlat_tb;
  logic clk = 1'b0, rst_n = 1'b0, flush_all = 1'b0;
  logic lk_req = 1'b0, lk_ready, lk_asid_skip = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic lk_done, lk_hit, lk_multi, lk_miss;
  logic [28:0] lk_paddr;
  logic [8:0]  lk_flags;
  logic rf_req_valid, rf_req_ready = 1'b0;
  logic [31:0] rf_req_vaddr;
  logic rf_rsp_valid = 1'b0, rf_rsp_found = 1'b0;
  logic [21:0] rf_rsp_vpn = '0;
  logic [7:0]  rf_rsp_asid = '0;
  logic [18:0] rf_rsp_ppn = '0;
  logic [8:0]  rf_rsp_flags = '0;
  logic mm_we = 1'b0, mm_data_sel = 1'b0;
  logic [1:0]  mm_entry = '0;
  logic [31:0] mm_wdata = '0, mm_rdata;
  logic [5:0]  lru_state;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [5:0] m_lru = '0;
  logic r_done, r_hit, r_multi, r_miss;
  logic [31:0] r_pa;
  logic [8:0]  r_fl;

  always #2.5 clk = ~clk;

  itlb_fetch_xlat u_dut (.*);

  // table of hit lookups: address, tag, skip, expected slot, address, flags
  localparam int NV = 6;
  localparam logic [31:0] V_VA [NV] = '{32'h0040_0ABC, 32'h0040_0FFF, 32'h1234_ABCD,
                                        32'h7F0F_1234, 32'h0000_2FFF, 32'h0040_0010};
  localparam logic [7:0]  V_AS [NV] = '{8'h05, 8'h05, 8'h33, 8'h05, 8'h05, 8'h09};
  localparam logic        V_SK [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [1:0]  V_IX [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
  localparam logic [31:0] V_PA [NV] = '{32'h0ABC_0ABC, 32'h0ABC_0FFF, 32'h0055_ABCD,
                                        32'h123F_1234, 32'h0000_87FF, 32'h0ABC_0010};
  localparam logic [8:0]  V_FL [NV] = '{9'h110, 9'h110, 9'h182, 9'h198, 9'h140, 9'h110};

  function automatic logic [1:0] m_victim(input logic [5:0] s);
    if (s[5] && s[4] && s[3])       return 2'd0;
    if (!s[5] && s[2] && s[1])      return 2'd1;
    if (!s[4] && !s[2] && s[0])     return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [5:0] m_touch(input logic [5:0] s, input logic [1:0] n);
    logic [5:0] t = s;
    if (n == 2'd0) begin t[5] = 0; t[4] = 0; t[3] = 0; end
    else if (n == 2'd1) begin t[5] = 1; t[2] = 0; t[1] = 0; end
    else if (n == 2'd2) begin t[4] = 1; t[2] = 1; t[0] = 0; end
    else begin t[3] = 1; t[1] = 1; t[0] = 1; end
    return t;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic mm_write(input logic sel, input logic [1:0] idx, input logic [31:0] v);
    @(negedge clk);
    mm_we = 1'b1; mm_data_sel = sel; mm_entry = idx; mm_wdata = v;
    @(negedge clk);
    mm_we = 1'b0;
  endtask

  task automatic mm_read(input logic sel, input logic [1:0] idx, output logic [31:0] v);
    mm_data_sel = sel; mm_entry = idx;
    #0.5;
    v = mm_rdata;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic skip,
                        input logic found, input logic [31:0] rsp_tag,
                        input logic [31:0] rsp_dat, input int dly);
    int cyc = 0;
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_asid = asid; lk_asid_skip = skip;
    @(negedge clk);
    lk_req = 1'b0;
    while (!lk_done && cyc < 40) begin
      if (rf_req_valid) begin
        for (int k = 0; k < dly; k++) begin
          chk("R7", "request held", {30'b0, rf_req_valid, lk_ready}, 32'h2);
          chk("R7", "request address held", rf_req_vaddr, va);
          @(negedge clk);
        end
        rf_req_ready = 1'b1;
        @(negedge clk);
        rf_req_ready = 1'b0;
        rf_rsp_valid = 1'b1; rf_rsp_found = found;
        rf_rsp_vpn = rsp_tag[31:10]; rf_rsp_asid = rsp_tag[7:0];
        rf_rsp_ppn = rsp_dat[28:10]; rf_rsp_flags = rsp_dat[8:0];
        @(negedge clk);
        rf_rsp_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    r_done = lk_done; r_hit = lk_hit; r_multi = lk_multi; r_miss = lk_miss;
    r_pa = {3'b0, lk_paddr}; r_fl = lk_flags;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  vic;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12", "lru after reset", {26'b0, lru_state}, 32'h0);
    chk("R12", "ready/done/request", {29'b0, lk_ready, lk_done, rf_req_valid}, 32'h4);
    for (int i = 0; i < 4; i++) begin
      mm_read(1'b0, 2'(i), rd); chk("R12", "tag word after reset", rd, 32'h0);
      mm_read(1'b1, 2'(i), rd); chk("R12", "data word after reset", rd, 32'h0);
    end

    // load one slot of each size; slot 2 written with ignored bits set
    mm_write(1'b0, 2'd0, 32'h0040_0105); mm_write(1'b1, 2'd0, 32'h0ABC_0110);
    mm_write(1'b0, 2'd1, 32'h1234_0107); mm_write(1'b1, 2'd1, 32'h0055_0182);
    mm_write(1'b0, 2'd2, 32'h7F00_0305); mm_write(1'b1, 2'd2, 32'hF230_01BD);
    mm_write(1'b0, 2'd3, 32'h0000_2D05); mm_write(1'b1, 2'd3, 32'h0000_8540);
    mm_read(1'b0, 2'd2, rd); chk("R10", "tag write drops bit 9", rd, 32'h7F00_0105);
    mm_read(1'b1, 2'd2, rd); chk("R10", "data write masks flags and top", rd, 32'h1230_0198);
    mm_read(1'b0, 2'd3, rd); chk("R9", "tag word layout", rd, 32'h0000_2D05);
    mm_read(1'b1, 2'd1, rd); chk("R9", "data word layout", rd, 32'h0055_0182);

    // R1 R2 R3 R5: table of single-match lookups
    for (int v = 0; v < NV; v++) begin
      lookup(V_VA[v], V_AS[v], V_SK[v], 1'b0, 32'h0, 32'h0, 0);
      chk(V_SK[v] ? "R2" : "R1", "hit outcome", {29'b0, r_done, r_hit, r_multi}, 32'h6);
      chk("R3", "translated address", r_pa, V_PA[v]);
      chk("R1", "flags", {23'b0, r_fl}, {23'b0, V_FL[v]});
      m_lru = m_touch(m_lru, V_IX[v]);
      chk("R5", "lru after hit", {26'b0, lru_state}, {26'b0, m_lru});
    end

    // R3 R8: one byte past the 1 KB page, second level has nothing
    lookup(32'h0000_3000, 8'h05, 1'b0, 1'b0, 32'h0, 32'h0, 0);
    chk("R8", "empty response outcome", {29'b0, r_done, r_hit, r_miss}, 32'h5);
    chk("R8", "lru unchanged", {26'b0, lru_state}, {26'b0, m_lru});
    mm_read(1'b1, m_victim(m_lru), rd);
    chk("R8", "victim slot untouched", rd, 32'h0055_0182);

    // R1 R4 R7: tag mismatch forces a fill, request accepted late
    vic = m_victim(m_lru);
    chk("R4", "victim from state 0x07", {30'b0, vic}, 32'h1);
    lookup(32'h0040_0123, 8'h06, 1'b0, 1'b1, 32'h0040_0006, 32'h0100_0135, 3);
    chk("R7", "fill outcome", {29'b0, r_done, r_hit, r_miss}, 32'h6);
    chk("R7", "fill address", r_pa, 32'h0100_0123);
    chk("R7", "fill flags masked", {23'b0, r_fl}, 32'h110);
    mm_read(1'b1, vic, rd); chk("R7", "installed data", rd, 32'h0100_0110);
    mm_read(1'b0, vic, rd); chk("R7", "installed tag", rd, 32'h0040_0106);
    m_lru = m_touch(m_lru, vic);
    chk("R5", "lru after fill", {26'b0, lru_state}, {26'b0, m_lru});

    // R1: same page, new tag now hits directly
    lookup(32'h0040_0123, 8'h06, 1'b0, 1'b0, 32'h0, 32'h0, 0);
    chk("R1", "direct hit after fill", r_pa, 32'h0100_0123);
    m_lru = m_touch(m_lru, vic);
    chk("R5", "lru after rehit", {26'b0, lru_state}, {26'b0, m_lru});

    // R6: tag skip makes two slots match
    lookup(32'h0040_0000, 8'h06, 1'b1, 1'b0, 32'h0, 32'h0, 0);
    chk("R6", "multi outcome", {29'b0, r_done, r_hit, r_multi}, 32'h5);
    chk("R6", "lru unchanged", {26'b0, lru_state}, {26'b0, m_lru});

    // R4: chain of fills visits the remaining victims
    for (int k = 0; k < 3; k++) begin
      logic [31:0] va;
      va  = 32'h6000_0000 + (k << 20);
      vic = m_victim(m_lru);
      lookup(va, 8'h05, 1'b0, 1'b1, va | 32'h5, ((32'h100 + k) << 10) | 32'h100, 0);
      chk("R4", "chain fill address", r_pa, (32'h100 + k) << 10);
      mm_read(1'b0, vic, rd); chk("R4", "chain victim slot", rd, va | 32'h105);
      m_lru = m_touch(m_lru, vic);
      chk("R4", "lru after chain fill", {26'b0, lru_state}, {26'b0, m_lru});
    end

    // R11: flush drops all slots
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mm_read(1'b0, 2'(i), rd);
      chk("R11", "valid cleared", {31'b0, rd[8]}, 32'h0);
    end
    lookup(32'h6000_0000, 8'h05, 1'b0, 1'b0, 32'h0, 32'h0, 0);
    chk("R11", "lookup after flush misses", {29'b0, r_done, r_hit, r_miss}, 32'h5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule